// File: doc/BRIEF.md
# CAN Bus Wakeup Pattern Detector

This block sits beside a CAN transceiver and does two things. First, it turns a two-bit software mode setting and the chip's operating mode into the state the transceiver should take: off, wakeup listener, receive-only, or full transmit and receive. Second, while the transceiver is in its wakeup state, it watches a synchronised dominant/recessive sample from the bus receiver. It looks for the bus wakeup sequence and, when it finds one, sets a sticky wakeup flag.

A wakeup is two dominant phases with a recessive phase between them. Each phase must be long enough, and the whole sequence must finish inside a timeout window. The window and the minimum phase lengths are parameters counted in system clock cycles. The window starts at the first dominant sample.

While the flag is pending and the transceiver is off or listening, the receive-data output is held low. The flag drops only on a clear strobe from software. In the receive-only and normal states the receive-data output follows the bus, and in normal state the transmit input reaches the bus driver.

Top module: `canWakeDetect`

## Requirements
- R1: After reset the wakeup flag is 0. In sleep mode with the bus recessive, the receive-data output is 1 and the transmit output is 1 (recessive).
- R2: In the normal (code 3), start-up (code 2) and flash (code 4) operating modes, mode bits 00, 01, 10 and 11 select the transceiver states off (0), wakeup (1), receive-only (2) and normal (3) respectively.
- R3: In standby (code 5), mode bits 01 select wakeup. Every other mode-bit value selects off.
- R4: In sleep (code 6) and fail-safe (code 7), the transceiver state is wakeup for every mode-bit value. When the thermal-shutdown input is 1, the state is off instead.
- R5: In power-up (code 0) and reset (code 1), the transceiver state is off for every mode-bit value.
- R6: In the wakeup state, the flag is set at the clock edge that samples the DOM_MIN-th dominant cycle of the second dominant phase. This requires a first dominant phase of at least DOM_MIN cycles and then a recessive phase of at least REC_MIN cycles. The flag is not set one cycle earlier.
- R7: A first dominant phase shorter than DOM_MIN cycles does not advance detection. A single dominant phase of any length never sets the flag.
- R8: A recessive phase shorter than REC_MIN cycles between two dominant phases does not complete a wakeup. The dominant phase that ends it is treated as a new first dominant phase.
- R9: The total sample count must not exceed WIN_MAX. Counting from the first dominant sample to the completing sample, a count of exactly WIN_MAX is a wakeup and WIN_MAX+1 is not.
- R10: In the off and wakeup states, the receive-data output is 0 while the flag is set and 1 otherwise. In receive-only and normal states, it is the inverse of the dominant input (dominant gives 0).
- R11: The transmit output equals the transmit input only in normal state. In every other state it is held at 1 (recessive) whatever the transmit input is.
- R12: Once set, the flag stays set until a clear strobe is sampled, and it is 0 on the edge after the clear. A wakeup completing in the same cycle as a clear leaves the flag set.
- R13: Bus activity while the transceiver is not in the wakeup state never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busDom | input | 1 | Synchronised bus sample, 1 = dominant |
| txIn | input | 1 | Transmit data from the protocol controller, 0 = dominant |
| modeBits | input | 2 | Software transceiver mode setting |
| opMode | input | 3 | Chip operating mode code (see R2 to R5) |
| thermalStop | input | 1 | Thermal shutdown active |
| flagClr | input | 1 | Wakeup flag clear strobe |
| xcvrState | output | 2 | Decoded transceiver state: 0 off, 1 wakeup, 2 receive-only, 3 normal |
| wakeFlag | output | 1 | Pending wakeup flag |
| rxOut | output | 1 | Receive-data level |
| txOut | output | 1 | Transmit level towards the bus driver, 1 = recessive |

## Verification
A detector stuck in a wrong phase shows up as a flag that rises one edge early or late. It also shows up as a flag that rises on a pattern with a short phase or an overlong window. The bench places its flag samples on the exact edge of the DOM_MIN-th second-phase dominant and one edge before it, so a one-cycle count error is seen at once. A corrupted flag register or clear path shows on rxOut in the off and wakeup states on the next edge. The bench sets up a wakeup that completes in the same cycle as a clear, so inverted clear priority is exposed within one cycle. Decode faults appear on xcvrState and txOut combinationally, in the same cycle the mode inputs change.

// File: rtl/canWakePkg.sv
package canWakePkg;

  typedef enum logic [2:0] {
    OPM_POWERUP  = 3'd0,
    OPM_RESET    = 3'd1,
    OPM_STARTUP  = 3'd2,
    OPM_NORMAL   = 3'd3,
    OPM_FLASH    = 3'd4,
    OPM_STANDBY  = 3'd5,
    OPM_SLEEP    = 3'd6,
    OPM_FAILSAFE = 3'd7
  } opMode_e;

  typedef enum logic [1:0] {
    XS_OFF    = 2'd0,
    XS_WAKE   = 2'd1,
    XS_RXONLY = 2'd2,
    XS_NORMAL = 2'd3
  } xcvrState_e;

  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_DOM1 = 2'd1,
    DS_REC  = 2'd2,
    DS_DOM2 = 2'd3
  } detState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic phaseRestart;
    logic phaseInc;
    logic winStart;
    logic winInc;
    logic hit;
  } detStrobe_t;

  // datapath -> control compare results
  typedef struct packed {
    logic domLongEnough;
    logic domReachNow;
    logic recLongEnough;
    logic winExpired;
  } detStatus_t;

endpackage

// File: rtl/canWakeModeDecode.sv
module canWakeModeDecode
  import canWakePkg::*;
(
  input  opMode_e    opMode,
  input  logic [1:0] modeBits,
  input  logic       thermalStop,
  output xcvrState_e xcvrState
);

  always_comb begin
    unique case (opMode)
      OPM_NORMAL, OPM_STARTUP, OPM_FLASH:
        xcvrState = xcvrState_e'(modeBits);
      OPM_STANDBY:
        xcvrState = (modeBits == 2'b01) ? XS_WAKE : XS_OFF;
      OPM_SLEEP, OPM_FAILSAFE:
        xcvrState = thermalStop ? XS_OFF : XS_WAKE;
      default:
        xcvrState = XS_OFF;
    endcase
  end

endmodule

// File: rtl/canWakeCtrl.sv
module canWakeCtrl
  import canWakePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busDom,
  input  xcvrState_e xcvrState,
  input  detStatus_t status,
  output detStrobe_t strb
);

  detState_e stQ, stD;
  logic listening;

  assign listening = (xcvrState == XS_WAKE);

  always_comb begin
    stD  = stQ;
    strb = '0;
    if (!listening) begin
      stD = DS_IDLE;
    end else if (stQ == DS_IDLE) begin
      if (busDom) begin
        stD               = DS_DOM1;
        strb.phaseRestart = 1'b1;
        strb.winStart     = 1'b1;
      end
    end else if (status.winExpired) begin
      stD = DS_IDLE;
    end else begin
      strb.winInc = 1'b1;
      unique case (stQ)
        DS_DOM1: begin
          if (busDom) begin
            strb.phaseInc = 1'b1;
          end else if (status.domLongEnough) begin
            stD               = DS_REC;
            strb.phaseRestart = 1'b1;
          end else begin
            stD = DS_IDLE;
          end
        end
        DS_REC: begin
          if (!busDom) begin
            strb.phaseInc = 1'b1;
          end else if (status.recLongEnough) begin
            stD               = DS_DOM2;
            strb.phaseRestart = 1'b1;
          end else begin
            // short gap: this dominant opens a fresh pattern
            stD               = DS_DOM1;
            strb.phaseRestart = 1'b1;
            strb.winStart     = 1'b1;
            strb.winInc       = 1'b0;
          end
        end
        DS_DOM2: begin
          if (busDom && status.domReachNow) begin
            strb.hit = 1'b1;
            stD      = DS_IDLE;
          end else if (busDom) begin
            strb.phaseInc = 1'b1;
          end else begin
            stD = DS_IDLE;
          end
        end
        default: stD = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= DS_IDLE;
    else       stQ <= stD;
  end

endmodule

// File: rtl/canWakeDatapath.sv
module canWakeDatapath
  import canWakePkg::*;
#(
  parameter int DOM_MIN = 4,
  parameter int REC_MIN = 3,
  parameter int WIN_MAX = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  detStrobe_t strb,
  input  logic       flagClr,
  input  logic       busDom,
  input  logic       txIn,
  input  xcvrState_e xcvrState,
  output detStatus_t status,
  output logic       wakeFlag,
  output logic       rxOut,
  output logic       txOut
);

  localparam int CNT_W = $clog2(WIN_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] phaseCnt, winCnt;
  logic flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      winCnt   <= '0;
      flagQ    <= 1'b0;
    end else begin
      if (strb.phaseRestart)
        phaseCnt <= CNT_W'(1);
      else if (strb.phaseInc && phaseCnt != CNT_MAX)
        phaseCnt <= phaseCnt + CNT_W'(1);

      if (strb.winStart)
        winCnt <= CNT_W'(1);
      else if (strb.winInc && winCnt != CNT_MAX)
        winCnt <= winCnt + CNT_W'(1);

      if (strb.hit)      flagQ <= 1'b1;
      else if (flagClr)  flagQ <= 1'b0;
    end
  end

  assign status.domLongEnough = phaseCnt >= CNT_W'(DOM_MIN);
  assign status.domReachNow   = ({1'b0, phaseCnt} + (CNT_W+1)'(1)) >= (CNT_W+1)'(DOM_MIN);
  assign status.recLongEnough = phaseCnt >= CNT_W'(REC_MIN);
  assign status.winExpired    = winCnt >= CNT_W'(WIN_MAX);

  assign wakeFlag = flagQ;
  assign rxOut = (xcvrState == XS_RXONLY || xcvrState == XS_NORMAL) ? ~busDom : ~flagQ;
  assign txOut = (xcvrState == XS_NORMAL) ? txIn : 1'b1;

endmodule

// File: rtl/canWakeDetect.sv
module canWakeDetect
  import canWakePkg::*;
#(
  parameter int DOM_MIN = 4,
  parameter int REC_MIN = 3,
  parameter int WIN_MAX = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busDom,
  input  logic       txIn,
  input  logic [1:0] modeBits,
  input  logic [2:0] opMode,
  input  logic       thermalStop,
  input  logic       flagClr,
  output logic [1:0] xcvrState,
  output logic       wakeFlag,
  output logic       rxOut,
  output logic       txOut
);

  xcvrState_e stateDec;
  detStrobe_t ctlStrobe;
  detStatus_t dpStatus;
  logic       detectHit;

  canWakeModeDecode u_decode (
    .opMode      (opMode_e'(opMode)),
    .modeBits    (modeBits),
    .thermalStop (thermalStop),
    .xcvrState   (stateDec)
  );

  canWakeCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busDom    (busDom),
    .xcvrState (stateDec),
    .status    (dpStatus),
    .strb      (ctlStrobe)
  );

  canWakeDatapath #(
    .DOM_MIN (DOM_MIN),
    .REC_MIN (REC_MIN),
    .WIN_MAX (WIN_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (ctlStrobe),
    .flagClr   (flagClr),
    .busDom    (busDom),
    .txIn      (txIn),
    .xcvrState (stateDec),
    .status    (dpStatus),
    .wakeFlag  (wakeFlag),
    .rxOut     (rxOut),
    .txOut     (txOut)
  );

  assign xcvrState = stateDec;
  assign detectHit = ctlStrobe.hit;

endmodule

// File: rtl/canWakeChecker.sv
module canWakeChecker
  import canWakePkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busDom,
  input logic       txIn,
  input logic [2:0] opMode,
  input logic       thermalStop,
  input logic       flagClr,
  input logic [1:0] xcvrState,
  input logic       wakeFlag,
  input logic       rxOut,
  input logic       txOut,
  input logic       hitStrobe
);

  assert_flag_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    wakeFlag && !flagClr |=> wakeFlag);

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && !hitStrobe |=> !wakeFlag);

  assert_rise_on_dominant_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(busDom));

  assert_rise_only_listening_R13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(xcvrState) == XS_WAKE);

  assert_rx_low_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    (xcvrState == XS_OFF || xcvrState == XS_WAKE) && wakeFlag |-> !rxOut);

  assert_tx_recessive_R11: assert property (@(posedge clk) disable iff (!rstN)
    xcvrState != XS_NORMAL |-> txOut);

  assert_tx_pass_R11: assert property (@(posedge clk) disable iff (!rstN)
    xcvrState == XS_NORMAL |-> txOut == txIn);

  assert_sleep_listen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == OPM_SLEEP || opMode == OPM_FAILSAFE) && !thermalStop |-> xcvrState == XS_WAKE);

  assert_powerup_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == OPM_POWERUP || opMode == OPM_RESET) |-> xcvrState == XS_OFF);

endmodule

bind canWakeDetect canWakeChecker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busDom      (busDom),
  .txIn        (txIn),
  .opMode      (opMode),
  .thermalStop (thermalStop),
  .flagClr     (flagClr),
  .xcvrState   (xcvrState),
  .wakeFlag    (wakeFlag),
  .rxOut       (rxOut),
  .txOut       (txOut),
  .hitStrobe   (detectHit)
);

// File: tb/canWakeDetect_bench.sv
module canWakeDetect_bench;

  localparam int DOM_MIN = 4;
  localparam int REC_MIN = 3;
  localparam int WIN_MAX = 20;

  localparam logic [1:0] S_OFF = 2'd0, S_WAKE = 2'd1, S_RX = 2'd2, S_NORM = 2'd3;
  localparam logic [2:0] M_PWR = 3'd0, M_RST = 3'd1, M_START = 3'd2, M_NORMAL = 3'd3,
                         M_FLASH = 3'd4, M_STBY = 3'd5, M_SLEEP = 3'd6, M_FAIL = 3'd7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       busDom = 1'b0;
  logic       txIn = 1'b1;
  logic [1:0] modeBits = 2'b00;
  logic [2:0] opMode = M_SLEEP;
  logic       thermalStop = 1'b0;
  logic       flagClr = 1'b0;
  logic [1:0] xcvrState;
  logic       wakeFlag, rxOut, txOut;

  canWakeDetect #(.DOM_MIN(DOM_MIN), .REC_MIN(REC_MIN), .WIN_MAX(WIN_MAX)) u_canWakeDetect (
    .clk(clk), .rstN(rstN), .busDom(busDom), .txIn(txIn), .modeBits(modeBits),
    .opMode(opMode), .thermalStop(thermalStop), .flagClr(flagClr),
    .xcvrState(xcvrState), .wakeFlag(wakeFlag), .rxOut(rxOut), .txOut(txOut)
  );

  typedef struct {
    logic [1:0] st;
    logic       flag;
    logic       rx;
    logic       tx;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (xcvrState !== it.st || wakeFlag !== it.flag || rxOut !== it.rx || txOut !== it.tx) begin
        fails++;
        $display("FAIL %s: state/flag/rx/tx actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
                 it.tag, xcvrState, wakeFlag, rxOut, txOut, it.st, it.flag, it.rx, it.tx);
      end
    end
  end

  // one bus sample per call: value applied, then consumed by the next rising edge
  task automatic drive(input logic b, input logic c);
    busDom  = b;
    flagClr = c;
    @(posedge clk);
    #2;
  endtask

  task automatic expectNow(input logic [1:0] st, input logic f, input logic rx,
                           input logic tx, input string tag);
    item_t it;
    flagClr = 1'b0;
    it.st = st; it.flag = f; it.rx = rx; it.tx = tx; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic setInputs(input logic [2:0] op, input logic [1:0] mb,
                           input logic th, input logic tx);
    opMode = op; modeBits = mb; thermalStop = th; txIn = tx;
  endtask

  task automatic runPattern(input int d1, input int r, input int d2, input logic clrLast);
    for (int i = 0; i < d1; i++) drive(1'b1, 1'b0);
    for (int i = 0; i < r; i++) drive(1'b0, 1'b0);
    for (int i = 0; i < d2; i++) drive(1'b1, (i == d2 - 1) ? clrLast : 1'b0);
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
  endtask

  function automatic logic [1:0] expState(input logic [2:0] op, input logic [1:0] mb,
                                          input logic th);
    if (op == M_NORMAL || op == M_START || op == M_FLASH) return mb;       // R2
    if (op == M_STBY) return (mb == 2'b01) ? S_WAKE : S_OFF;               // R3
    if (op == M_SLEEP || op == M_FAIL) return th ? S_OFF : S_WAKE;         // R4
    return S_OFF;                                                          // R5
  endfunction

  function automatic bit patternValid(input int d1, input int r, input int d2);
    return d1 >= DOM_MIN && r >= REC_MIN && d2 >= DOM_MIN && (d1 + r + DOM_MIN) <= WIN_MAX;
  endfunction

  initial begin
    logic [2:0] ops[3];
    ops[0] = M_NORMAL; ops[1] = M_START; ops[2] = M_FLASH;

    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    expectNow(S_WAKE, 1'b0, 1'b1, 1'b1, "R1 reset state");

    // R2 / R11: decode in active modes, tx passes only in normal state
    foreach (ops[k]) begin
      for (int b = 0; b < 4; b++) begin
        logic [1:0] es;
        setInputs(ops[k], 2'(b), 1'b0, 1'b0);
        es = expState(ops[k], 2'(b), 1'b0);
        expectNow(es, 1'b0, 1'b1, (es == S_NORM) ? 1'b0 : 1'b1, "R2/R11 active-mode decode");
      end
    end

    for (int b = 0; b < 4; b++) begin
      setInputs(M_STBY, 2'(b), 1'b0, 1'b0);
      expectNow(expState(M_STBY, 2'(b), 1'b0), 1'b0, 1'b1, 1'b1, "R3 standby decode");
    end

    for (int b = 0; b < 4; b++) begin
      setInputs(M_PWR, 2'(b), 1'b0, 1'b1);
      expectNow(S_OFF, 1'b0, 1'b1, 1'b1, "R5 power-up off");
      setInputs(M_RST, 2'(b), 1'b0, 1'b1);
      expectNow(S_OFF, 1'b0, 1'b1, 1'b1, "R5 reset off");
    end

    for (int b = 0; b < 4; b++) begin
      setInputs(M_SLEEP, 2'(b), 1'b0, 1'b1);
      expectNow(S_WAKE, 1'b0, 1'b1, 1'b1, "R4 sleep listens");
      setInputs(M_FAIL, 2'(b), 1'b1, 1'b1);
      expectNow(S_OFF, 1'b0, 1'b1, 1'b1, "R4 thermal shutdown off");
    end

    setInputs(M_SLEEP, 2'b00, 1'b0, 1'b1);

    // R7: short first dominant, then a lone long dominant
    runPattern(3, 5, 6, 1'b0);
    flush(25);
    expectNow(S_WAKE, patternValid(3, 5, 6), 1'b1, 1'b1, "R7 short first dominant");
    runPattern(10, 0, 0, 1'b0);
    flush(25);
    expectNow(S_WAKE, 1'b0, 1'b1, 1'b1, "R7 single dominant");

    // R8: recessive gap too short
    runPattern(5, 2, 5, 1'b0);
    flush(25);
    expectNow(S_WAKE, patternValid(5, 2, 5), 1'b1, 1'b1, "R8 short recessive");

    // R9: one sample over the window
    runPattern(8, 9, 4, 1'b0);
    flush(5);
    expectNow(S_WAKE, patternValid(8, 9, 4), 1'b1, 1'b1, "R9 window exceeded");

    // R6: minimum pattern, checked one edge early and on the exact edge
    runPattern(4, 3, 3, 1'b0);
    expectNow(S_WAKE, 1'b0, 1'b1, 1'b1, "R6 one dominant short");
    drive(1'b1, 1'b0);
    expectNow(S_WAKE, patternValid(4, 3, 4), 1'b0, 1'b1, "R6 minimum wakeup");

    flush(10);
    expectNow(S_WAKE, 1'b1, 1'b0, 1'b1, "R12 flag held");
    drive(1'b0, 1'b1);
    expectNow(S_WAKE, 1'b0, 1'b1, 1'b1, "R12 clear");

    // R9 boundary: exactly WIN_MAX samples
    runPattern(8, 8, 4, 1'b0);
    expectNow(S_WAKE, patternValid(8, 8, 4), 1'b0, 1'b1, "R9 window boundary");

    drive(1'b0, 1'b1);
    expectNow(S_WAKE, 1'b0, 1'b1, 1'b1, "R12 clear before priority case");
    runPattern(4, 3, 4, 1'b1);
    expectNow(S_WAKE, 1'b1, 1'b0, 1'b1, "R12 detection beats clear");

    // R10: rx follows bus in receive-only, shows flag when off
    setInputs(M_NORMAL, 2'b10, 1'b0, 1'b1);
    drive(1'b1, 1'b0);
    expectNow(S_RX, 1'b1, 1'b0, 1'b1, "R10 rx dominant");
    drive(1'b0, 1'b0);
    expectNow(S_RX, 1'b1, 1'b1, 1'b1, "R10 rx recessive");
    setInputs(M_NORMAL, 2'b00, 1'b0, 1'b1);
    expectNow(S_OFF, 1'b1, 1'b0, 1'b1, "R10 off with pending flag");

    // R11: tx path
    setInputs(M_NORMAL, 2'b11, 1'b0, 1'b0);
    expectNow(S_NORM, 1'b1, 1'b1, 1'b0, "R11 tx dominant passes");
    setInputs(M_NORMAL, 2'b11, 1'b0, 1'b1);
    expectNow(S_NORM, 1'b1, 1'b1, 1'b1, "R11 tx recessive passes");
    setInputs(M_SLEEP, 2'b01, 1'b0, 1'b0);
    expectNow(S_WAKE, 1'b1, 1'b0, 1'b1, "R11 tx ignored in wakeup");

    // R13: valid pattern while off
    drive(1'b0, 1'b1);
    expectNow(S_WAKE, 1'b0, 1'b1, 1'b0 | 1'b1, "R12 clear before R13");
    setInputs(M_NORMAL, 2'b00, 1'b0, 1'b1);
    runPattern(4, 3, 4, 1'b0);
    flush(2);
    expectNow(S_OFF, 1'b0, 1'b1, 1'b1, "R13 no detection when off");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule